// File: doc/BRIEF.md
# Converter Calibration and Conversion Sequencer

This block is the control state machine of a self-calibrating delta-sigma converter. It runs on the master clock. It watches two command pins: a calibrate-select level and a start pin. From them it decides which of four phases the converter is in: wake-up, standby, calibration or conversion. Each phase lasts a fixed number of master-clock cycles, which a single down-counter measures.

The block tells the rest of the converter what to do through several outputs. It gives one busy flag per active phase. It pulses a one-cycle strobe when a calibration or a conversion begins. It pulses a one-cycle done strobe when a conversion word is complete, which tells the output port to update.

Commands that arrive while another phase is running are handled by fixed rules:
- A start level seen during wake-up is held and executed when wake-up ends.
- A fresh start edge restarts a running conversion.
- A fresh start edge restarts a running calibration only when calibrate-select is high.
- A calibration that ends while the start pin is still high goes straight into a conversion.
- Holding the start pin high gives back-to-back words.

Both command pins pass through a two-flop synchroniser. All edge detection uses the synchronised start level.

Top module: `cvt_sequencer`

## Requirements
- R1: Reset places the block in wake-up (state code 01). Wake-up lasts WAKE_CYC (default 1800) master-clock cycles. It is followed by standby (code 00) when no command is pending. Wake-up is never re-entered without reset.
- R2: A high start level seen during wake-up, including one held through reset, is latched as a command. It executes as soon as wake-up ends. It becomes a calibration if calibrate-select was high, and a conversion otherwise.
- R3: In standby, a synchronised rising start edge with calibrate-select high begins calibration (code 10). Calibration lasts CAL_CYC (default 3246) cycles. If the start pin is low when calibration ends, the block returns to standby.
- R4: In standby, a rising start edge with calibrate-select low begins conversion (code 11). Conversion lasts CONV_FIRST_CYC (default 1624) cycles. It ends with conv_done and a return to standby when the start pin is low.
- R5: When calibration ends with the start pin high, a conversion of CONV_FIRST_CYC cycles follows at once.
- R6: While the start pin stays high, conversions repeat. The conv_done strobes are spaced CONV_NEXT_CYC (default 1622) cycles apart.
- R7: During calibration, a new rising start edge with calibrate-select high aborts the calibration and starts a full new one.
- R8: During calibration, a new rising start edge with calibrate-select low is ignored. Calibration still ends CAL_CYC cycles after it began.
- R9: During conversion, a rising start edge with calibrate-select low abandons the current word with no conv_done. A new conversion of CONV_FIRST_CYC cycles starts.
- R10: During conversion, a rising start edge with calibrate-select high abandons the word without conv_done and begins calibration.
- R11: conv_done is high for exactly one cycle, and only at the end of a conversion. The cal_start and conv_start strobes coincide with the first cycle of their phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cal_i | input | 1 | Calibrate-select level (asynchronous) |
| conv_i | input | 1 | Start pin (asynchronous) |
| state_o | output | 2 | Phase code: 00 standby, 01 wake-up, 10 calibrate, 11 convert |
| wake_busy_o | output | 1 | High during wake-up |
| cal_busy_o | output | 1 | High during calibration |
| conv_busy_o | output | 1 | High during conversion |
| cal_start_o | output | 1 | One-cycle strobe on the first calibration cycle |
| conv_start_o | output | 1 | One-cycle strobe on the first conversion cycle |
| conv_done_o | output | 1 | One-cycle strobe when a conversion word completes |

## Verification
The start pin is driven in four patterns: a single short pulse from standby, a level held through reset and wake-up, a level held high across calibration into repeated conversions, and a second low-to-high toggle in the middle of a running phase.

The mid-phase toggle is paired once with each calibrate-select level, in both calibration and conversion. The measured phase length then separates four outcomes: a restart, an ignored edge, an abandoned word, and a switch to calibration. The held-high pattern separates the first-word length from the repeat-word length, and it tests the chaining of calibration into conversion.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

    typedef enum logic [1:0] {
        ST_STBY = 2'b00,
        ST_WAKE = 2'b01,
        ST_CAL  = 2'b10,
        ST_CONV = 2'b11
    } seq_state_e;

    typedef enum logic [1:0] {
        LEN_CAL   = 2'd0,
        LEN_FIRST = 2'd1,
        LEN_NEXT  = 2'd2
    } len_sel_e;

    typedef struct packed {
        logic valid;
        logic is_cal;
    } pend_cmd_t;

    typedef struct packed {
        seq_state_e nxt;
        logic       load;
        len_sel_e   len_sel;
        logic       done;
        logic       cal_start;
        logic       conv_start;
    } step_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Step record that starts a calibration or a first conversion word.
    function automatic step_t launch(input logic as_cal);
        step_t s;
        s.nxt        = as_cal ? ST_CAL : ST_CONV;
        s.load       = 1'b1;
        s.len_sel    = as_cal ? LEN_CAL : LEN_FIRST;
        s.done       = 1'b0;
        s.cal_start  = as_cal;
        s.conv_start = !as_cal;
        return s;
    endfunction

endpackage

// File: rtl/cvt_in_sync.sv
module cvt_in_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic         rise0_o
);
    logic       prev0_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[STAGES-2:0], async_i[b]};
        end
        assign lvl_o[b] = sh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev0_q <= 1'b0;
        else     prev0_q <= lvl_o[0];
    end

    assign rise0_o = lvl_o[0] && !prev0_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise0_o |=> !rise0_o); // R3

endmodule

// File: rtl/cvt_cycle_timer.sv
module cvt_cycle_timer #(
    parameter int            CW      = 12,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= RST_VAL;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o); // R6

endmodule

// File: rtl/cvt_sequencer.sv
module cvt_sequencer
    import cvt_seq_pkg::*;
#(
    parameter int WAKE_CYC       = 1800,
    parameter int CAL_CYC        = 3246,
    parameter int CONV_FIRST_CYC = 1624,
    parameter int CONV_NEXT_CYC  = 1622,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_i,
    input  logic       conv_i,
    output logic [1:0] state_o,
    output logic       wake_busy_o,
    output logic       cal_busy_o,
    output logic       conv_busy_o,
    output logic       cal_start_o,
    output logic       conv_start_o,
    output logic       conv_done_o
);
    localparam int            MAXC     = max4(WAKE_CYC, CAL_CYC, CONV_FIRST_CYC, CONV_NEXT_CYC);
    localparam int            CW       = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAKE_LD  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] CAL_LD   = CW'(CAL_CYC - 1);
    localparam logic [CW-1:0] FIRST_LD = CW'(CONV_FIRST_CYC - 1);
    localparam logic [CW-1:0] NEXT_LD  = CW'(CONV_NEXT_CYC - 1);

    logic [1:0]    lvl;
    logic          conv_lvl, cal_lvl, conv_rise;
    logic [CW-1:0] t_cnt, load_val;
    logic          t_zero;
    seq_state_e    st_q;
    pend_cmd_t     pend_q, pend_n;
    step_t         step;
    logic          done_q, cal_start_q, conv_start_q;

    // Bit 0 carries the start pin so its edge is detected.
    cvt_in_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({cal_i, conv_i}),
        .lvl_o   (lvl),
        .rise0_o (conv_rise)
    );
    assign conv_lvl = lvl[0];
    assign cal_lvl  = lvl[1];

    cvt_cycle_timer #(.CW(CW), .RST_VAL(WAKE_LD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (step.load),
        .load_val_i (load_val),
        .cnt_o      (t_cnt),
        .zero_o     (t_zero)
    );

    always_comb begin
        step = '{nxt: st_q, load: 1'b0, len_sel: LEN_CAL, done: 1'b0,
                 cal_start: 1'b0, conv_start: 1'b0};
        pend_n = pend_q;
        case (st_q)
            ST_WAKE: begin
                if (conv_lvl) begin
                    pend_n.valid  = 1'b1;
                    pend_n.is_cal = cal_lvl;
                end
                if (t_zero) begin
                    if (pend_n.valid) step = launch(pend_n.is_cal);
                    else              step.nxt = ST_STBY;
                end
            end
            ST_STBY: begin
                if (conv_rise) step = launch(cal_lvl);
            end
            ST_CAL: begin
                if (conv_rise && cal_lvl) step = launch(1'b1);
                else if (t_zero) begin
                    if (conv_lvl) step = launch(1'b0);
                    else          step.nxt = ST_STBY;
                end
            end
            ST_CONV: begin
                if (conv_rise) step = launch(cal_lvl);
                else if (t_zero) begin
                    step.done = 1'b1;
                    if (conv_lvl) begin
                        step.load    = 1'b1;
                        step.len_sel = LEN_NEXT;
                    end else begin
                        step.nxt = ST_STBY;
                    end
                end
            end
            default: step.nxt = ST_STBY;
        endcase
    end

    always_comb begin
        case (step.len_sel)
            LEN_CAL:   load_val = CAL_LD;
            LEN_FIRST: load_val = FIRST_LD;
            LEN_NEXT:  load_val = NEXT_LD;
            default:   load_val = FIRST_LD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_WAKE;
            pend_q       <= '0;
            done_q       <= 1'b0;
            cal_start_q  <= 1'b0;
            conv_start_q <= 1'b0;
        end else begin
            st_q         <= step.nxt;
            pend_q       <= pend_n;
            done_q       <= step.done;
            cal_start_q  <= step.cal_start;
            conv_start_q <= step.conv_start;
        end
    end

    assign state_o      = st_q;
    assign wake_busy_o  = (st_q == ST_WAKE);
    assign cal_busy_o   = (st_q == ST_CAL);
    assign conv_busy_o  = (st_q == ST_CONV);
    assign cal_start_o  = cal_start_q;
    assign conv_start_o = conv_start_q;
    assign conv_done_o  = done_q;

    AST_WAKE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_WAKE) |=> (st_q != ST_WAKE)); // R1

    AST_STBY_LEAVE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_STBY && st_q != ST_STBY) |-> $past(conv_rise)); // R3

    AST_CAL_EXIT_AT_END: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_CAL && st_q == ST_STBY) |-> $past(t_zero)); // R3

    AST_CAL_CHAINS: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_CAL && $past(t_zero) && $past(conv_lvl) && !$past(conv_rise))
        |-> (st_q == ST_CONV)); // R5

    AST_DONE_FROM_CONV: assert property (@(posedge clk) disable iff (rst)
        conv_done_o |-> ($past(st_q) == ST_CONV && $past(t_zero))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_done_o |=> !conv_done_o); // R11

    AST_CONV_START_STATE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> (st_q == ST_CONV)); // R11

    AST_CAL_START_STATE: assert property (@(posedge clk) disable iff (rst)
        cal_start_o |-> (st_q == ST_CAL)); // R11

endmodule

// File: tb/cvt_sequencer_tb.sv
module cvt_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_i = 1'b0;
    logic       conv_i = 1'b0;
    logic [1:0] state_o;
    logic       wake_busy_o, cal_busy_o, conv_busy_o;
    logic       cal_start_o, conv_start_o, conv_done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cvt_sequencer u_dut (
        .clk          (clk),
        .rst          (rst),
        .cal_i        (cal_i),
        .conv_i       (conv_i),
        .state_o      (state_o),
        .wake_busy_o  (wake_busy_o),
        .cal_busy_o   (cal_busy_o),
        .conv_busy_o  (conv_busy_o),
        .cal_start_o  (cal_start_o),
        .conv_start_o (conv_start_o),
        .conv_done_o  (conv_done_o)
    );

    localparam logic [1:0] S_STBY = 2'b00;
    localparam logic [1:0] S_WAKE = 2'b01;
    localparam logic [1:0] S_CAL  = 2'b10;
    localparam logic [1:0] S_CONV = 2'b11;

    typedef struct packed {
        logic       c_cal;
        logic [1:0] st;
        int         tog;
        logic       t_cal;
        int         exp_n;
        logic       exp_done;
        logic [1:0] exp_exit;
        int         req;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b11,    0, 1'b0, 1624, 1'b1, 2'b00,  4}, // R4 plain conversion
        '{1'b1, 2'b10,    0, 1'b0, 3246, 1'b0, 2'b00,  3}, // R3 plain calibration
        '{1'b1, 2'b10, 1000, 1'b1, 4248, 1'b0, 2'b00,  7}, // R7 restart: 1000 + 3246 + 2
        '{1'b1, 2'b10, 1000, 1'b0, 3246, 1'b0, 2'b00,  8}, // R8 toggle ignored
        '{1'b0, 2'b11,  500, 1'b0, 2126, 1'b1, 2'b00,  9}, // R9 restart: 500 + 1624 + 2
        '{1'b0, 2'b11,  500, 1'b1,  502, 1'b0, 2'b10, 10}  // R10 switch to calibration
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input vec_t v, output int n, output logic [1:0] ex_st,
                           output logic ex_done);
        int  j;
        bit  seen;
        j = 0; seen = 0; n = 0; ex_st = 2'b00; ex_done = 1'b0;
        cal_i  = v.c_cal;
        conv_i = 1'b1;
        while (j < 20000) begin
            @(negedge clk);
            j++;
            if (j == 4) conv_i = 1'b0;
            if (state_o == v.st) begin
                n++;
                seen = 1;
                if (v.tog != 0) begin
                    if (n == v.tog) begin cal_i = v.t_cal; conv_i = 1'b1; end
                    if (n == v.tog + 4) conv_i = 1'b0;
                end
            end else if (seen) begin
                ex_st   = state_o;
                ex_done = conv_done_o;
                break;
            end
        end
    endtask

    task automatic wait_stby();
        for (int k = 0; k < 10000; k++) begin
            if (state_o == S_STBY) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(10 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int         n;
        logic [1:0] ex_st;
        logic       ex_done;

        // R1: reset state and wake-up length with no command
        repeat (3) @(negedge clk);
        chk(state_o == S_WAKE, "R1 reset state", state_o, S_WAKE);
        chk(conv_done_o == 1'b0, "R1 reset done", conv_done_o, 0);
        rst = 1'b0;
        n = 0;
        while (state_o == S_WAKE && n < 5000) begin n++; @(negedge clk); end
        chk(n == 1800, "R1 wake length", n, 1800);
        chk(state_o == S_STBY, "R1 standby after wake", state_o, S_STBY);
        repeat (20) @(negedge clk);
        chk(state_o == S_STBY, "R1 standby held", state_o, S_STBY);

        // Table of commands issued from standby
        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i], n, ex_st, ex_done);
            chk(n == VECS[i].exp_n, $sformatf("R%0d phase length", VECS[i].req), n, VECS[i].exp_n);
            chk(ex_st == VECS[i].exp_exit, $sformatf("R%0d exit state", VECS[i].req), ex_st, VECS[i].exp_exit);
            chk(ex_done == VECS[i].exp_done, $sformatf("R%0d done at exit", VECS[i].req), ex_done, VECS[i].exp_done);
            wait_stby();
            cal_i = 1'b0;
            repeat (5) @(negedge clk);
        end

        // R2, R5, R6, R11: command held through reset and wake-up
        rst = 1'b1; cal_i = 1'b1; conv_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (state_o == S_WAKE && n < 5000) begin n++; @(negedge clk); end
        chk(n == 1800, "R2 wake length with pending command", n, 1800);
        chk(state_o == S_CAL, "R2 pending calibration runs", state_o, S_CAL);
        cal_i = 1'b0;
        n = 0;
        while (state_o == S_CAL && n < 10000) begin n++; @(negedge clk); end
        chk(n == 3246, "R5 calibration length", n, 3246);
        chk(state_o == S_CONV, "R5 calibration chains to conversion", state_o, S_CONV);
        n = 0;
        while (state_o == S_CONV && !conv_done_o && n < 5000) begin n++; @(negedge clk); end
        chk(n == 1624, "R5 first word length", n, 1624);
        chk(conv_done_o == 1'b1, "R11 done at word end", conv_done_o, 1);
        @(negedge clk);
        chk(conv_done_o == 1'b0, "R11 done one cycle", conv_done_o, 0);
        n = 1;
        while (!conv_done_o && n < 5000) begin n++; @(negedge clk); end
        chk(n == 1622, "R6 repeat word spacing", n, 1622);
        conv_i = 1'b0;
        @(negedge clk);
        while (state_o == S_CONV && n < 20000) begin n++; @(negedge clk); end
        chk(state_o == S_STBY, "R6 standby after last word", state_o, S_STBY);
        chk(conv_done_o == 1'b1, "R4 done on return to standby", conv_done_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule